// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places incoming frames into software-supplied receive buffers. Software keeps a ring of descriptors in shared memory. Each descriptor takes 16 bytes: a control word at offset 0, a length word at offset 4 and a buffer pointer at offset 8. Software hands a descriptor to the engine by setting its active bit. When a frame starts, the engine reads the current descriptor. If the descriptor is active, the engine learns the buffer capacity and address from it. It then streams the frame bytes into the buffer as little-endian 32-bit words. Finally it writes back the received length and an error flag, and clears the active bit so that software owns the descriptor again.

The descriptor ring starts at `ring_base`. Descriptor n sits at `ring_base + 16*n`. A descriptor whose list-end bit is set sends the engine back to the first descriptor once that descriptor has been used. Receive is gated by an enable flag, which software sets with a one-cycle request pulse. If a frame arrives while the current descriptor still belongs to software, the ring is full. The engine then discards the frame, clears its enable flag and counts a missed frame. Software drains the ring and pulses the request again to resume.

The memory port is a single-word port. A read request returns its data on the next cycle. A write completes in the cycle of the request.

Top module: `rxd_engine`

## Requirements
- R1: After reset, `rx_en` is 0, `miss_cnt` is 0, `in_ready` is 0 and no memory request is made while no frame is offered.
- R2: A pulse on `en_set` sets `rx_en`. With `rx_en` set, a frame that lands on an active descriptor has its stored bytes written little-endian into 32-bit words from the buffer address: byte i goes to word i/4, lane i%4. Lanes above the last stored byte of the final word are written as zero.
- R3: The engine writes back the length word with the capacity unchanged in bits 31:16 and the stored byte count in bits 15:0.
- R4: The engine writes back the control word with the active bit (bit 31) cleared and the list-end bit (bit 30) kept as read. Bit 8 (frame error) is set when `in_err` was high on any beat of the frame or the frame was truncated. Every other bit is written as zero.
- R5: Bytes beyond the capacity are consumed but not written. The stored length then equals the capacity and bit 8 is set. A frame exactly as long as its capacity is not flagged.
- R6: After each completed frame the engine moves to the next descriptor at the following 16-byte offset. After a descriptor with the list-end bit set, it returns to `ring_base`. A dropped frame does not move the ring.
- R7: A frame that meets an inactive descriptor is consumed and discarded. `rx_en` is cleared and `miss_cnt` rises by one. The descriptor's words are left untouched.
- R8: While `rx_en` is 0, offered frames are consumed and discarded with no memory access, and each one raises `miss_cnt` by one.
- R9: `miss_cnt` changes by at most one per cycle and only ever increases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | Receive request pulse; sets the enable flag |
| ring_base | input | AW | Byte address of descriptor 0 |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 1 | Frame fault reported by the source |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| rx_en | output | 1 | Receive enable flag |
| miss_cnt | output | MISS_W | Count of discarded frames |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
On every cycle, the assertions check the following: the missed-frame count only steps upward by one, and a disabled engine in its idle state stays off the memory port. A software-owned descriptor must clear the enable flag on the next edge. A control write-back must never leave the active bit set. Buffer writes must stay below the capacity, the stored count must never pass it, and a wrap must land on the ring base. The bench scenarios are the only way to show the data itself: the byte order and zero padding in the buffer, the length and flag values written back, preservation of the list-end bit, untouched descriptors after a drop, and the ring position surviving dropped frames.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
  localparam int ACT_BIT    = 31;
  localparam int LEND_BIT   = 30;
  localparam int FERR_BIT   = 8;
  localparam int DESC_BYTES = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_CTL, S_LEN, S_BUF, S_RECV, S_DROP, S_WLEN, S_WCTL
  } rx_state_t;

  // control word written back: ownership returned, list-end kept
  function automatic logic [31:0] ctl_word(input logic lend, input logic ferr);
    logic [31:0] w;
    w = '0;
    w[LEND_BIT] = lend;
    w[FERR_BIT] = ferr;
    return w;
  endfunction

  function automatic logic [31:0] len_word(input logic [15:0] cap, input logic [15:0] n);
    return {cap, n};
  endfunction

  // drop a byte into its lane of a partially built word
  function automatic logic [31:0] lane_merge(input logic [31:0] acc, input logic [7:0] b,
                                             input logic [1:0] lane);
    return acc | (32'(b) << {lane, 3'b000});
  endfunction
endpackage

// File: rtl/rxd_ring_ptr.sv
`timescale 1ns/1ps
module rxd_ring_ptr import rxd_pkg::*; #(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] ring_base,
  output logic [AW-1:0] desc_addr
);
  localparam int SH = $clog2(DESC_BYTES);
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       idx <= '0;
    else if (advance) idx <= wrap ? '0 : idx + IDX_W'(1);

  assign desc_addr = ring_base + (AW'(idx) << SH);

  // R6
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap) |=> (desc_addr == ring_base));
endmodule

// File: rtl/rxd_packer.sv
`timescale 1ns/1ps
module rxd_packer import rxd_pkg::*; #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] cap_in,
  input  logic          beat,
  input  logic          last,
  input  logic [7:0]    data,
  output logic          wr_now,
  output logic [31:0]   wr_data,
  output logic [LW-1:0] wr_off,
  output logic [LW-1:0] stored,
  output logic [LW-1:0] cap,
  output logic          trunc
);
  logic [LW-1:0] cnt;
  logic [31:0]   acc;
  logic          room, keep;
  logic [1:0]    lane;

  assign room    = cnt < cap;
  assign keep    = beat && room;
  assign lane    = cnt[1:0];
  assign wr_now  = keep && (lane == 2'd3 || last || (cnt + LW'(1)) == cap);
  assign wr_data = lane_merge(acc, data, lane);
  assign wr_off  = {cnt[LW-1:2], 2'b00};
  assign stored  = cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap <= '0; cnt <= '0; acc <= '0; trunc <= 1'b0;
    end else if (load) begin
      cap <= cap_in; cnt <= '0; acc <= '0; trunc <= 1'b0;
    end else begin
      if (keep) begin
        cnt <= cnt + LW'(1);
        acc <= wr_now ? '0 : wr_data;
      end
      if (beat && !room) trunc <= 1'b1;
    end

  // R5
  stored_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stored <= cap);
  // R5
  trunc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trunc |-> (stored == cap));
endmodule

// File: rtl/rxd_ctrl.sv
`timescale 1ns/1ps
module rxd_ctrl import rxd_pkg::*; #(
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  output logic              rx_en,
  output logic [MISS_W-1:0] miss_cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic [AW-1:0]     desc_addr,
  output logic              advance,
  output logic              wrap,
  output logic              pk_load,
  output logic              pk_beat,
  input  logic              pk_wr_now,
  input  logic [31:0]       pk_wr_data,
  input  logic [LW-1:0]     pk_wr_off,
  input  logic [LW-1:0]     pk_stored,
  input  logic [LW-1:0]     pk_cap,
  input  logic              pk_trunc
);
  rx_state_t     state, nxt;
  logic          drop_evt, own_miss;
  logic          lend_q, ferr_q;
  logic [AW-1:0] buf_q;

  always_comb begin
    nxt = state; in_ready = 1'b0; mem_req = 1'b0; mem_we = 1'b0;
    mem_addr = desc_addr; mem_wdata = '0; pk_load = 1'b0; pk_beat = 1'b0;
    advance = 1'b0; drop_evt = 1'b0; own_miss = 1'b0;
    case (state)
      S_IDLE: if (in_valid) begin
        if (rx_en) begin mem_req = 1'b1; nxt = S_CTL; end
        else begin drop_evt = 1'b1; nxt = S_DROP; end
      end
      S_CTL: if (mem_rdata[ACT_BIT]) begin
        mem_req = 1'b1; mem_addr = desc_addr + AW'(4); nxt = S_LEN;
      end else begin
        drop_evt = 1'b1; own_miss = 1'b1; nxt = S_DROP;
      end
      S_LEN: begin
        pk_load = 1'b1; mem_req = 1'b1; mem_addr = desc_addr + AW'(8); nxt = S_BUF;
      end
      S_BUF: nxt = S_RECV;
      S_RECV: begin
        in_ready = 1'b1;
        if (in_valid) begin
          pk_beat = 1'b1;
          if (pk_wr_now) begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = buf_q + AW'(pk_wr_off); mem_wdata = pk_wr_data;
          end
          if (in_last) nxt = S_WLEN;
        end
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) nxt = S_IDLE;
      end
      S_WLEN: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr + AW'(4);
        mem_wdata = len_word(pk_cap, pk_stored); nxt = S_WCTL;
      end
      S_WCTL: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_wdata = ctl_word(lend_q, ferr_q | pk_trunc);
        advance = 1'b1; nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign wrap = lend_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; rx_en <= 1'b0; miss_cnt <= '0;
      lend_q <= 1'b0; ferr_q <= 1'b0; buf_q <= '0;
    end else begin
      state <= nxt;
      if (own_miss)    rx_en <= 1'b0;
      else if (en_set) rx_en <= 1'b1;
      if (drop_evt) miss_cnt <= miss_cnt + MISS_W'(1);
      if (state == S_CTL) lend_q <= mem_rdata[LEND_BIT];
      if (state == S_LEN) ferr_q <= 1'b0;
      else if (state == S_RECV && in_valid && in_err) ferr_q <= 1'b1;
      if (state == S_BUF) buf_q <= AW'(mem_rdata);
    end

  // R9
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_cnt == $past(miss_cnt) || miss_cnt == $past(miss_cnt) + MISS_W'(1)));
  // R7
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CTL && !mem_rdata[ACT_BIT]) |=> (!rx_en && state == S_DROP));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !rx_en) |-> !mem_req);
  // R4
  ctl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state != S_RECV && mem_addr == desc_addr) |-> !mem_wdata[ACT_BIT]);
  // R5
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RECV && mem_we) |-> ((mem_addr - buf_q) < AW'(pk_cap)));
endmodule

// File: rtl/rxd_engine.sv
`timescale 1ns/1ps
module rxd_engine #(
  parameter int AW     = 32,
  parameter int IDX_W  = 8,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic [AW-1:0]     ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  output logic              rx_en,
  output logic [MISS_W-1:0] miss_cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int LW = 16;

  logic [AW-1:0] desc_addr;
  logic          advance, wrap, pk_load, pk_beat, pk_wr_now, pk_trunc;
  logic [31:0]   pk_wr_data;
  logic [LW-1:0] pk_wr_off, pk_stored, pk_cap;

  rxd_ring_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(advance), .wrap(wrap),
    .ring_base(ring_base), .desc_addr(desc_addr));

  rxd_packer #(.LW(LW)) u_pack (
    .clk(clk), .rst_n(rst_n), .load(pk_load), .cap_in(mem_rdata[31:16]),
    .beat(pk_beat), .last(in_last), .data(in_data), .wr_now(pk_wr_now),
    .wr_data(pk_wr_data), .wr_off(pk_wr_off), .stored(pk_stored),
    .cap(pk_cap), .trunc(pk_trunc));

  rxd_ctrl #(.AW(AW), .LW(LW), .MISS_W(MISS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .in_valid(in_valid),
    .in_last(in_last), .in_err(in_err), .in_ready(in_ready), .rx_en(rx_en),
    .miss_cnt(miss_cnt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .desc_addr(desc_addr), .advance(advance), .wrap(wrap),
    .pk_load(pk_load), .pk_beat(pk_beat), .pk_wr_now(pk_wr_now),
    .pk_wr_data(pk_wr_data), .pk_wr_off(pk_wr_off), .pk_stored(pk_stored),
    .pk_cap(pk_cap), .pk_trunc(pk_trunc));
endmodule

// File: tb/sim_rxd_engine.sv
`timescale 1ns/1ps
module sim_rxd_engine;
  localparam int NV = 7;
  localparam int FLEN [NV] = '{5, 8, 12, 3, 1, 6, 2};
  localparam int CAPS [NV] = '{64, 64, 8, 64, 64, 6, 0};
  localparam int EIN  [NV] = '{0, 0, 0, 1, 0, 0, 0};
  localparam int XLEN [NV] = '{5, 8, 8, 3, 1, 6, 0};
  localparam int XERR [NV] = '{0, 0, 1, 1, 0, 0, 1};
  localparam logic [31:0] BASE = 32'h40;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 1'b0, rst_n = 1'b0, en_set = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = 8'h0;
  logic in_ready, rx_en, mem_req, mem_we;
  logic [15:0] miss_cnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  logic bk_we = 1'b0;
  logic [7:0] bk_idx = 8'h0;
  logic [31:0] bk_data = 32'h0;
  int total = 0, bad = 0, req_cnt = 0, xidx = 0;

  always #4 clk = ~clk;

  rxd_engine u0 (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .ring_base(BASE),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .rx_en(rx_en), .miss_cnt(miss_cnt), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    else if (mem_req) mem_rdata <= mem[mem_addr[9:2]];
    if (bk_we) mem[bk_idx] <= bk_data;
    if (mem_req) req_cnt <= req_cnt + 1;
  end

  function automatic logic [7:0] byte_f(input int seed, input int i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    bk_we = 1'b1; bk_idx = addr[9:2]; bk_data = data;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic pulse_en();
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
  endtask

  function automatic logic [31:0] daddr(input int idx);
    return BASE + 32'(idx * 16);
  endfunction
  function automatic logic [31:0] baddr(input int idx);
    return 32'h100 + 32'(idx * 64);
  endfunction

  task automatic arm(input int idx, input int cap, input bit act);
    logic [31:0] w0;
    for (int w = 0; w < 16; w++) poke(baddr(idx) + 32'(w * 4), SENT);
    w0 = 32'h0000_00F0;
    if (act) w0[31] = 1'b1;
    if (idx == 3) w0[30] = 1'b1;
    poke(daddr(idx), w0);
    poke(daddr(idx) + 4, {16'(cap), 16'hABCD});
    poke(daddr(idx) + 8, baddr(idx));
  endtask

  task automatic send(input int n, input int seed, input bit err);
    bit got;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = byte_f(seed, i);
      in_last = (i == n - 1); in_err = err && (i == n - 1);
      forever begin
        #1; got = in_ready;
        @(posedge clk);
        if (got) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int idx, input int seed,
                             input int stored, input int cap, input bit ferr);
    logic [31:0] e0, e1, eb, got;
    bit ok;
    int bad_w;
    e0 = 32'h0;
    if (idx == 3) e0[30] = 1'b1;
    if (ferr) e0[8] = 1'b1;
    e1 = {16'(cap), 16'(stored)};
    chk(mem[daddr(idx) >> 2] == e0, req, "control word", mem[daddr(idx) >> 2], e0);
    chk(mem[(daddr(idx) + 4) >> 2] == e1, req, "length word", mem[(daddr(idx) + 4) >> 2], e1);
    ok = 1'b1; bad_w = 0; eb = 32'h0; got = 32'h0;
    for (int w = 0; w < 16; w++) begin
      logic [31:0] ex;
      if (w * 4 >= stored) ex = SENT;
      else begin
        ex = 32'h0;
        for (int k = 0; k < 4; k++)
          if (w * 4 + k < stored) ex[k*8 +: 8] = byte_f(seed, w * 4 + k);
      end
      if (ok && mem[(baddr(idx) >> 2) + w] != ex) begin
        ok = 1'b0; bad_w = w; eb = ex; got = mem[(baddr(idx) >> 2) + w];
      end
    end
    chk(ok, req, $sformatf("buffer word %0d", bad_w), got, eb);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem_rdata = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rx_en == 1'b0 && miss_cnt == 16'h0 && in_ready == 1'b0 && mem_req == 1'b0,
        "R1", "reset outputs", {rx_en, in_ready, mem_req, 13'h0, miss_cnt}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b0 && rx_en == 1'b0, "R1", "idle after reset", {31'h0, mem_req}, 32'h0);
    pulse_en();
    chk(rx_en == 1'b1, "R2", "enable pulse", {31'h0, rx_en}, 32'h1);

    // table walk: R2 R3 R4 R5 R6
    for (int j = 0; j < NV; j++) begin
      arm(xidx, CAPS[j], 1'b1);
      send(FLEN[j], j, EIN[j] != 0);
      check_frame(j == 2 || j == 5 || j == 6 ? "R5" : (j == 3 ? "R4/R6" : "R2/R3"),
                  xidx, j, XLEN[j], CAPS[j], XERR[j] != 0);
      chk(rx_en == 1'b1 && miss_cnt == 16'h0, "R2", "enable kept, no miss",
          {15'h0, rx_en, miss_cnt}, 32'h0001_0000);
      xidx = (xidx == 3) ? 0 : xidx + 1;
    end

    // R7 inactive descriptor at index 3
    arm(xidx, 64, 1'b0);
    send(4, 30, 1'b0);
    chk(rx_en == 1'b0, "R7", "enable cleared on full ring", {31'h0, rx_en}, 32'h0);
    chk(miss_cnt == 16'd1, "R7", "miss count", {16'h0, miss_cnt}, 32'd1);
    chk(mem[daddr(xidx) >> 2] == 32'h4000_00F0, "R7", "control untouched",
        mem[daddr(xidx) >> 2], 32'h4000_00F0);
    chk(mem[(daddr(xidx) + 4) >> 2] == 32'h0040_ABCD, "R7", "length untouched",
        mem[(daddr(xidx) + 4) >> 2], 32'h0040_ABCD);

    // R8 disabled engine
    begin
      int snap;
      snap = req_cnt;
      send(3, 31, 1'b0);
      chk(miss_cnt == 16'd2, "R8", "miss count while off", {16'h0, miss_cnt}, 32'd2);
      chk(req_cnt == snap, "R8", "no memory access while off", 32'(req_cnt), 32'(snap));
    end

    // R6 ring position kept across drops, then wrap
    pulse_en();
    arm(xidx, 64, 1'b1);
    send(7, 32, 1'b0);
    check_frame("R6", xidx, 32, 7, 64, 1'b0);
    xidx = 0;
    arm(xidx, 64, 1'b1);
    send(4, 33, 1'b0);
    check_frame("R6", xidx, 33, 4, 64, 1'b0);
    chk(miss_cnt == 16'd2 && rx_en == 1'b1, "R9", "count steady after resume",
        {15'h0, rx_en, miss_cnt}, 32'h0001_0002);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule